// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and drives three verdict lines: the first operand is greater, equal, or smaller. The work is split into 4-bit comparator stages. Each stage first looks at its own nibbles. It passes on a verdict from a lower-order stage only when its own nibbles match.

The top module chains a parameterized number of stages, two by default, to form an 8-bit comparator. The lowest stage takes its verdict from three cascade inputs on the top ports. A standalone compare ties the "equal" cascade input high and the other two low. Two or more tops can also be chained by wiring one top's outputs into the next top's cascade inputs. The block is purely combinational: it has no clock, no reset and no registers.

Top module: `cmp_chain`

## Requirements
- R1: With cascade inputs {gt,eq,lt} = {0,1,0}, `gt_o` is high exactly when `a_i` > `b_i` as unsigned numbers.
- R2: With cascade inputs {0,1,0}, `lt_o` is high exactly when `a_i` < `b_i` as unsigned numbers.
- R3: With cascade inputs {0,1,0}, `eq_o` is high exactly when `a_i` == `b_i`.
- R4: Exactly one of `gt_o`, `eq_o` and `lt_o` is high whenever exactly one cascade input is high.
- R5: When `a_i` == `b_i`, the outputs {gt_o,eq_o,lt_o} copy the cascade inputs {casc_gt_i,casc_eq_i,casc_lt_i} bit for bit. This holds for all eight cascade patterns, including those that are not one-hot.
- R6: When `a_i` != `b_i`, the cascade inputs have no effect. The outputs are the same for all eight cascade patterns, `eq_o` is low, and exactly one of `gt_o`/`lt_o` is high.
- R7: The most significant differing bit decides the result, whatever the lower bits hold. For example, 0x80 against 0x7F gives greater, and 0x08 against 0x07 gives greater.
- R8: The lower nibble decides the result only when the upper nibbles are equal. For example, 0x35 against 0x36 gives less, and 0x45 against 0x36 gives greater.
- R9: The outputs settle within the same cycle in which the operands change. No clock edge lies on the path from input to output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, unsigned, bit 7 most significant |
| b_i | input | 8 | Second operand, unsigned, bit 7 most significant |
| casc_gt_i | input | 1 | "Greater" verdict from a lower-order comparator |
| casc_eq_i | input | 1 | "Equal" verdict from a lower-order comparator (tie high when unused) |
| casc_lt_i | input | 1 | "Less" verdict from a lower-order comparator |
| gt_o | output | 1 | First operand greater |
| eq_o | output | 1 | Operands equal (and cascade says equal) |
| lt_o | output | 1 | First operand smaller |

## Verification
The block holds no state, so an internal fault shows at the ports in the same cycle as the operand pattern that sensitizes it.

A wrong bit-equality term or a wrong priority term only shows for pairs whose most significant differing bit sits at the affected position. For that reason every one of the 65,536 operand pairs is compared against a behavioural compare.

A broken link between the two stages only shows when the upper nibbles are equal. A broken cascade gate only shows when the cascade inputs are non-default. Equal and unequal pairs are therefore driven under all eight cascade patterns, so that both passing the cascade through and ignoring it are observed.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Three-line verdict carried between comparator stages.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

endpackage

// File: rtl/nib_match.sv
// Per-bit equality vector: one XNOR per bit pair.
module nib_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] same_o
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign same_o[gi] = ~(a_i[gi] ^ b_i[gi]);
    end
  endgenerate

endmodule

// File: rtl/msb_decide.sv
// Finds the most significant differing bit and reports its direction.
module msb_decide #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] same_i,
  output logic         gt_o,
  output logic         lt_o
);

  logic [W-1:0] win_gt;
  logic [W-1:0] win_lt;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pos
      logic upper_same;
      if (gi == W - 1) begin : g_top
        assign upper_same = 1'b1;
      end else begin : g_low
        assign upper_same = &same_i[W-1:gi+1];
      end
      assign win_gt[gi] = upper_same & a_i[gi] & ~b_i[gi];
      assign win_lt[gi] = upper_same & ~a_i[gi] & b_i[gi];
    end
  endgenerate

  assign gt_o = |win_gt;
  assign lt_o = |win_lt;

endmodule

// File: rtl/cmp_stage.sv
// One comparator slice; the cascade verdict is used only on a local tie.
module cmp_stage
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  verdict_t     casc_i,
  output verdict_t     res_o
);

  logic [W-1:0] same;
  logic         loc_gt;
  logic         loc_lt;
  logic         tie;

  nib_match #(.W(W)) u_match (
    .a_i    (a_i),
    .b_i    (b_i),
    .same_o (same)
  );

  msb_decide #(.W(W)) u_decide (
    .a_i    (a_i),
    .b_i    (b_i),
    .same_i (same),
    .gt_o   (loc_gt),
    .lt_o   (loc_lt)
  );

  assign tie = &same;

  always_comb begin
    res_o.gt = loc_gt | (tie & casc_i.gt);
    res_o.eq = tie & casc_i.eq;
    res_o.lt = loc_lt | (tie & casc_i.lt);
  end

endmodule

// File: rtl/cmp_chain.sv
// Chain of comparator slices, least significant slice first.
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int STAGES = 2,
  localparam int DATA_W = NIB_W * STAGES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              casc_gt_i,
  input  logic              casc_eq_i,
  input  logic              casc_lt_i,
  output logic              gt_o,
  output logic              eq_o,
  output logic              lt_o
);

  verdict_t link [STAGES+1];

  assign link[0] = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

  genvar si;
  generate
    for (si = 0; si < STAGES; si++) begin : g_stage
      cmp_stage #(.W(NIB_W)) u_stage (
        .a_i    (a_i[si*NIB_W +: NIB_W]),
        .b_i    (b_i[si*NIB_W +: NIB_W]),
        .casc_i (link[si]),
        .res_o  (link[si+1])
      );
    end
  endgenerate

  assign gt_o = link[STAGES].gt;
  assign eq_o = link[STAGES].eq;
  assign lt_o = link[STAGES].lt;

endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              casc_gt_i,
  input logic              casc_eq_i,
  input logic              casc_lt_i,
  input logic              gt_o,
  input logic              eq_o,
  input logic              lt_o
);

  logic plain;
  logic onehot_in;

  assign plain     = ({casc_gt_i, casc_eq_i, casc_lt_i} == 3'b010);
  assign onehot_in = ($countones({casc_gt_i, casc_eq_i, casc_lt_i}) == 1);

  always_comb begin
    if (plain) begin
      AST_GT_UNSIGNED: assert (gt_o == (a_i > b_i)); // R1
      AST_LT_UNSIGNED: assert (lt_o == (a_i < b_i)); // R2
      AST_EQ_UNSIGNED: assert (eq_o == (a_i == b_i)); // R3
    end
    if (onehot_in) begin
      AST_ONE_VERDICT: assert ($countones({gt_o, eq_o, lt_o}) == 1); // R4
    end
    if (a_i == b_i) begin
      AST_TIE_PASSES: assert ({gt_o, eq_o, lt_o} == {casc_gt_i, casc_eq_i, casc_lt_i}); // R5
    end else begin
      AST_DIFF_DECIDES: assert (!eq_o && (gt_o != lt_o) && (gt_o == (a_i > b_i))); // R6
    end
  end

endmodule

bind cmp_chain cmp_chain_chk #(.DATA_W(DATA_W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .casc_gt_i (casc_gt_i),
  .casc_eq_i (casc_eq_i),
  .casc_lt_i (casc_lt_i),
  .gt_o      (gt_o),
  .eq_o      (eq_o),
  .lt_o      (lt_o)
);

// File: tb/cmp_chain_tb.sv
module cmp_chain_tb;

  typedef struct {
    logic [2:0] exp;
    string      tag;
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] casc;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic       casc_gt_i = 1'b0;
  logic       casc_eq_i = 1'b1;
  logic       casc_lt_i = 1'b0;
  logic       gt_o, eq_o, lt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  cmp_chain u_dut (
    .a_i       (a_i),
    .b_i       (b_i),
    .casc_gt_i (casc_gt_i),
    .casc_eq_i (casc_eq_i),
    .casc_lt_i (casc_lt_i),
    .gt_o      (gt_o),
    .eq_o      (eq_o),
    .lt_o      (lt_o)
  );

  function automatic logic [2:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [2:0] casc);
    if (a > b)      return 3'b100;
    else if (a < b) return 3'b001;
    else            return casc;
  endfunction

  // Driver: applies inputs on a rising edge and queues the expected verdict.
  task automatic drive(input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] casc, input string tag);
    item_t it;
    @(posedge clk);
    a_i = a;
    b_i = b;
    {casc_gt_i, casc_eq_i, casc_lt_i} = casc;
    it.exp  = model(a, b, casc);
    it.tag  = tag;
    it.a    = a;
    it.b    = b;
    it.casc = casc;
    sb_q.push_back(it);
  endtask

  // Monitor: samples on the falling edge, half a cycle after the drive (R9).
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({gt_o, eq_o, lt_o} !== it.exp) begin
        fails++;
        $display("FAIL %s a=%02h b=%02h casc=%03b actual=%03b expected=%03b",
                 it.tag, it.a, it.b, it.casc, {gt_o, eq_o, lt_o}, it.exp);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Reset-state: inputs at idle values give "equal"
    drive(8'h00, 8'h00, 3'b010, "R3 idle");
    // R7: most significant differing bit wins
    drive(8'h80, 8'h7F, 3'b010, "R7");
    drive(8'h7F, 8'h80, 3'b010, "R7");
    drive(8'h08, 8'h07, 3'b010, "R7");
    drive(8'h01, 8'h00, 3'b010, "R7");
    // R8: low nibble decides only on equal high nibbles
    drive(8'h35, 8'h36, 3'b010, "R8");
    drive(8'h45, 8'h36, 3'b010, "R8");
    drive(8'hA9, 8'hA9, 3'b010, "R8");
    // R5: equal operands pass any cascade pattern through
    for (int p = 0; p < 8; p++) begin
      drive(8'h00, 8'h00, 3'(p), "R5");
      drive(8'hC3, 8'hC3, 3'(p), "R5");
      drive(8'hFF, 8'hFF, 3'(p), "R5");
    end
    // R6: unequal operands ignore the cascade inputs
    for (int p = 0; p < 8; p++) begin
      drive(8'h12, 8'h13, 3'(p), "R6");
      drive(8'hF0, 8'h0F, 3'(p), "R6");
      drive(8'h3A, 8'h35, 3'(p), "R6");
    end
    // R4: one-hot cascade inputs, exactly one output high
    drive(8'h55, 8'h55, 3'b100, "R4");
    drive(8'h55, 8'h55, 3'b001, "R4");
    drive(8'h55, 8'h56, 3'b100, "R4");
    // R1 R2 R3: exhaustive sweep against the behavioural compare
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        drive(8'(x), 8'(y), 3'b010, "R1/R2/R3 sweep");
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule